// File: doc/BRIEF.md
# SIMD Lane Enable Generator

This unit decides, for one vector instruction at a time, which of the 32 SIMD lanes may write their result. It combines four things: the lane count requested by the instruction, a lane-group selector that names the first lane, the thread's execution mask, and a predicate vector. The unit also checks the request and raises a flag when the size encoding is illegal, when the first lane is not a multiple of the lane count, or when the lane group runs past the dispatch width. When any flag is raised, no lane is enabled.

The execution mask register lives inside the unit. A dispatch pulse sets it to ones across the dispatched width. Control-flow logic outside the unit can overwrite it through an update port. All results are registered once. They appear in the cycle after the instruction is presented, so a bench can compare them on every clock.

Top module: `simd_lane_enable`

## Requirements
- R1: `issue_size` codes 0 to 5 select 2^code lanes (1, 2, 4, 8, 16, 32). Codes 6 and 7 set `err_size_q`, leave `err_align_q` and `err_range_q` low, and enable no lane.
- R2: The start lane is 4 × `issue_ctrl[2:0]`, so the start lane is one of 0, 4, 8 … 28.
- R3: When `issue_ctrl[3]` is 0, lane c is enabled only if three conditions hold: start ≤ c < start + count, `exec_mask_q[c]` is 1, and the effective predicate bit c is 1.
- R4: When `issue_ctrl[3]` is 1, the execution mask is ignored. Every lane in the group whose effective predicate bit is 1 is enabled, including lanes whose mask bit is 0.
- R5: The effective predicate is `issue_pred ^ {32{issue_pred_inv}}`. Bit c of it gates lane c, so predicate bits are selected at the same lane positions as the mask bits.
- R6: `err_align_q` is set when start lane modulo lane count is nonzero, for a legal size.
- R7: `err_range_q` is set when start + count is greater than the dispatch width. A group that ends exactly at the last dispatched lane is legal.
- R8: When any error flag is set, `lane_en_q` is all zeros in that same output cycle.
- R9: A dispatch pulse loads the execution mask with ones in the low 8, 16 or 32 bits, for `disp_width` codes 0, 1 and 2 respectively; code 3 is also 32. The same pulse records the dispatch width. A dispatch takes priority over a mask update in the same cycle.
- R10: A mask update loads `mask_upd_data`, with bits at or above the dispatch width cleared. With neither a dispatch nor an update, the mask holds its value. An instruction issued in the same cycle as an update or a dispatch uses the mask value from before that cycle.
- R11: Outputs appear exactly one cycle after `issue_valid`. A cycle without an issue gives `out_valid_q` 0, `lane_en_q` all zeros and all flags 0.
- R12: After reset, the mask is all zeros, the dispatch width is 8, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disp_valid | input | 1 | Dispatch pulse: initialise the mask and width |
| disp_width | input | 2 | Dispatch width code: 0 means 8 lanes, 1 means 16, 2 or 3 means 32 |
| mask_upd_valid | input | 1 | Control-flow mask update strobe |
| mask_upd_data | input | 32 | New execution mask value |
| issue_valid | input | 1 | Instruction present this cycle |
| issue_size | input | 3 | Lane count code |
| issue_ctrl | input | 4 | Bit 3 selects no-mask; bits 2:0 select the lane group |
| issue_pred | input | 32 | Predicate vector, one bit per lane |
| issue_pred_inv | input | 1 | Invert the predicate |
| lane_en_q | output | 32 | Registered per-lane write enable |
| out_valid_q | output | 1 | Registered issue valid |
| err_size_q | output | 1 | Illegal size code |
| err_align_q | output | 1 | Start lane not aligned to the lane count |
| err_range_q | output | 1 | Lane group exceeds the dispatch width |
| exec_mask_q | output | 32 | Current execution mask |

## Verification
Two functions can fall in the same cycle: a mask rewrite (update or dispatch) and an instruction issue. The bench provokes this with a directed case in which both the update and the issue fall in one cycle, and with random stimulus that often drives all three inputs together. In that case the enable must be judged against the mask from before the edge, and the new mask must be judged one cycle later. The bench model tracks the mask and the width separately from the expected enable, so the bench can judge both results without assuming the order in which they happen.

// File: rtl/simd_lane_enable_pkg.sv
package simd_lane_enable_pkg;
    typedef enum logic [1:0] {
        DW_QUARTER = 2'd0,
        DW_HALF    = 2'd1,
        DW_FULL    = 2'd2,
        DW_FULL_X  = 2'd3
    } disp_width_e;

    function automatic int width_lanes(input logic [1:0] code, input int lanes);
        case (disp_width_e'(code))
            DW_QUARTER: return lanes / 4;
            DW_HALF:    return lanes / 2;
            default:    return lanes;
        endcase
    endfunction
endpackage

// File: rtl/lane_size_dec.sv
module lane_size_dec #(
    parameter int LANES  = 32,
    parameter int CODE_W = 3,
    parameter int CNT_W  = $clog2(LANES) + 1
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  count,
    output logic              legal
);
    localparam int MAX_CODE = $clog2(LANES);

    always_comb begin
        legal = (int'(code) <= MAX_CODE);
        count = legal ? (CNT_W'(1) << code) : '0;
    end
endmodule

// File: rtl/lane_window.sv
module lane_window #(
    parameter int LANES = 32,
    parameter int OFF_W = 3,
    parameter int STEP  = 4,
    parameter int CNT_W = $clog2(LANES) + 1
) (
    input  logic [OFF_W-1:0] off_code,
    input  logic [CNT_W-1:0] count,
    input  logic             legal,
    input  logic [CNT_W-1:0] width,
    output logic [LANES-1:0] window,
    output logic             err_align,
    output logic             err_range
);
    localparam int EW = CNT_W + 2;

    logic [EW-1:0] start_v;
    logic [EW-1:0] end_v;
    logic [EW-1:0] cnt_v;

    always_comb begin
        cnt_v     = EW'(count);
        start_v   = EW'(off_code) * EW'(STEP);
        end_v     = start_v + cnt_v;
        err_align = legal && ((start_v & (cnt_v - EW'(1))) != '0);
        err_range = legal && (end_v > EW'(width));
    end

    for (genvar c = 0; c < LANES; c++) begin : g_lane
        assign window[c] = legal && (EW'(c) >= start_v) && (EW'(c) < end_v);
    end
endmodule

// File: rtl/lane_mask_reg.sv
module lane_mask_reg
    import simd_lane_enable_pkg::*;
#(
    parameter int LANES = 32,
    parameter int CNT_W = $clog2(LANES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    input  logic [1:0]       disp_width,
    input  logic             upd_valid,
    input  logic [LANES-1:0] upd_data,
    output logic [LANES-1:0] mask_q,
    output logic [CNT_W-1:0] width_q
);
    typedef struct packed {
        logic [LANES-1:0] mask;
        logic [CNT_W-1:0] width;
    } mreg_t;

    mreg_t st_d, st_q;

    function automatic logic [LANES-1:0] low_ones(input logic [CNT_W-1:0] w);
        logic [LANES-1:0] o;
        for (int c = 0; c < LANES; c++) o[c] = (c < int'(w));
        return o;
    endfunction

    always_comb begin
        st_d = st_q;
        if (disp_valid) begin
            st_d.width = CNT_W'(width_lanes(disp_width, LANES));
            st_d.mask  = low_ones(st_d.width);
        end else if (upd_valid) begin
            st_d.mask  = upd_data & low_ones(st_q.width);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask  <= '0;
            st_q.width <= CNT_W'(LANES / 4);
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q  = st_q.mask;
    assign width_q = st_q.width;
endmodule

// File: rtl/simd_lane_enable.sv
module simd_lane_enable #(
    parameter int LANES  = 32,
    parameter int SIZE_W = 3,
    parameter int CTRL_W = 4,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [1:0]        disp_width,
    input  logic              mask_upd_valid,
    input  logic [LANES-1:0]  mask_upd_data,
    input  logic              issue_valid,
    input  logic [SIZE_W-1:0] issue_size,
    input  logic [CTRL_W-1:0] issue_ctrl,
    input  logic [LANES-1:0]  issue_pred,
    input  logic              issue_pred_inv,
    output logic [LANES-1:0]  lane_en_q,
    output logic              out_valid_q,
    output logic              err_size_q,
    output logic              err_align_q,
    output logic              err_range_q,
    output logic [LANES-1:0]  exec_mask_q
);
    localparam int CNT_W = $clog2(LANES) + 1;
    localparam int OFF_W = CTRL_W - 1;

    typedef struct packed {
        logic [LANES-1:0] en;
        logic             valid;
        logic             e_size;
        logic             e_align;
        logic             e_range;
    } out_t;

    out_t st_d, st_q;

    logic [CNT_W-1:0] count;
    logic             legal;
    logic [CNT_W-1:0] width;
    logic [LANES-1:0] window;
    logic             w_align;
    logic             w_range;

    lane_mask_reg #(.LANES(LANES), .CNT_W(CNT_W)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .disp_valid (disp_valid),
        .disp_width (disp_width),
        .upd_valid  (mask_upd_valid),
        .upd_data   (mask_upd_data),
        .mask_q     (exec_mask_q),
        .width_q    (width)
    );

    lane_size_dec #(.LANES(LANES), .CODE_W(SIZE_W), .CNT_W(CNT_W)) u_size (
        .code  (issue_size),
        .count (count),
        .legal (legal)
    );

    lane_window #(.LANES(LANES), .OFF_W(OFF_W), .STEP(STEP), .CNT_W(CNT_W)) u_win (
        .off_code  (issue_ctrl[OFF_W-1:0]),
        .count     (count),
        .legal     (legal),
        .width     (width),
        .window    (window),
        .err_align (w_align),
        .err_range (w_range)
    );

    always_comb begin
        logic [LANES-1:0] sel;
        logic [LANES-1:0] pred_eff;
        logic             bad;
        pred_eff      = issue_pred ^ {LANES{issue_pred_inv}};
        sel           = issue_ctrl[CTRL_W-1] ? {LANES{1'b1}} : exec_mask_q;
        st_d.valid    = issue_valid;
        st_d.e_size   = issue_valid && !legal;
        st_d.e_align  = issue_valid && w_align;
        st_d.e_range  = issue_valid && w_range;
        bad           = st_d.e_size || st_d.e_align || st_d.e_range;
        st_d.en       = (issue_valid && !bad) ? (window & sel & pred_eff) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lane_en_q   = st_q.en;
    assign out_valid_q = st_q.valid;
    assign err_size_q  = st_q.e_size;
    assign err_align_q = st_q.e_align;
    assign err_range_q = st_q.e_range;
endmodule

// File: rtl/simd_lane_enable_chk.sv
module simd_lane_enable_chk
    import simd_lane_enable_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int SIZE_W = 3,
    parameter int CTRL_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              disp_valid,
    input logic [1:0]        disp_width,
    input logic              mask_upd_valid,
    input logic [LANES-1:0]  mask_upd_data,
    input logic              issue_valid,
    input logic [SIZE_W-1:0] issue_size,
    input logic [CTRL_W-1:0] issue_ctrl,
    input logic [LANES-1:0]  issue_pred,
    input logic              issue_pred_inv,
    input logic [LANES-1:0]  lane_en_q,
    input logic              out_valid_q,
    input logic              err_size_q,
    input logic              err_align_q,
    input logic              err_range_q,
    input logic [LANES-1:0]  exec_mask_q
);
    localparam int MAX_CODE = $clog2(LANES);

    function automatic logic [LANES-1:0] disp_ones(input logic [1:0] code);
        logic [LANES-1:0] o;
        for (int c = 0; c < LANES; c++) o[c] = (c < width_lanes(code, LANES));
        return o;
    endfunction

    AST_SIZE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(issue_valid && (int'(issue_size) > MAX_CODE)) |-> (err_size_q && lane_en_q == '0)); // R1
    AST_SIZE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        err_size_q |-> (!err_align_q && !err_range_q)); // R1
    AST_PRED_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_q |-> ((lane_en_q & ~$past(issue_pred ^ {LANES{issue_pred_inv}})) == '0)); // R5
    AST_ERR_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (err_size_q || err_align_q || err_range_q) |-> (lane_en_q == '0)); // R8
    AST_DISPATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(disp_valid) |-> (exec_mask_q == disp_ones($past(disp_width)))); // R9
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!disp_valid && !mask_upd_valid) |-> $stable(exec_mask_q)); // R10
    AST_ISSUE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(issue_valid) |-> out_valid_q); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_q |-> (lane_en_q == '0 && !err_size_q && !err_align_q && !err_range_q)); // R11
endmodule

bind simd_lane_enable simd_lane_enable_chk #(
    .LANES(LANES), .SIZE_W(SIZE_W), .CTRL_W(CTRL_W)
) u_chk (.*);

// File: tb/simd_lane_enable_test.sv
`timescale 1ns/1ps
module simd_lane_enable_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 1'b0;
    logic [1:0]  disp_width = '0;
    logic        mask_upd_valid = 1'b0;
    logic [31:0] mask_upd_data = '0;
    logic        issue_valid = 1'b0;
    logic [2:0]  issue_size = '0;
    logic [3:0]  issue_ctrl = '0;
    logic [31:0] issue_pred = '0;
    logic        issue_pred_inv = 1'b0;
    logic [31:0] lane_en_q;
    logic        out_valid_q;
    logic        err_size_q;
    logic        err_align_q;
    logic        err_range_q;
    logic [31:0] exec_mask_q;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [31:0] m_mask = '0;
    int          m_width = 8;

    always #2 clk = ~clk;

    simd_lane_enable uut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_width(disp_width),
        .mask_upd_valid(mask_upd_valid), .mask_upd_data(mask_upd_data),
        .issue_valid(issue_valid), .issue_size(issue_size), .issue_ctrl(issue_ctrl),
        .issue_pred(issue_pred), .issue_pred_inv(issue_pred_inv),
        .lane_en_q(lane_en_q), .out_valid_q(out_valid_q),
        .err_size_q(err_size_q), .err_align_q(err_align_q), .err_range_q(err_range_q),
        .exec_mask_q(exec_mask_q)
    );

    function automatic logic [31:0] ones_below(input int w);
        logic [31:0] o;
        for (int c = 0; c < 32; c++) o[c] = (c < w);
        return o;
    endfunction

    function automatic int code_width(input logic [1:0] code);
        return (code == 2'd0) ? 8 : (code == 2'd1) ? 16 : 32;
    endfunction

    // returns {valid, err_size, err_align, err_range, enable[31:0]}
    function automatic logic [35:0] model(input logic [31:0] mask, input int width,
            input logic iv, input logic [2:0] sz, input logic [3:0] ct,
            input logic [31:0] pr, input logic pi);
        logic [31:0] en = '0;
        logic es = 0, ea = 0, er = 0;
        int k, i;
        if (!iv) return '0;
        if (sz > 3'd5) begin
            es = 1;
        end else begin
            k  = 1 << sz;
            i  = 4 * int'(ct[2:0]);
            ea = (i % k) != 0;
            er = (i + k) > width;
        end
        if (!(es || ea || er))
            for (int c = 0; c < 32; c++)
                en[c] = (c >= i) && (c < i + k) && (ct[3] || mask[c]) && (pr[c] ^ pi);
        return {1'b1, es, ea, er, en};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cycle(input logic dv, input logic [1:0] dw, input logic uv, input logic [31:0] ud,
            input logic iv, input logic [2:0] sz, input logic [3:0] ct,
            input logic [31:0] pr, input logic pi, input string tag);
        logic [35:0] e;
        string t;
        disp_valid = dv; disp_width = dw; mask_upd_valid = uv; mask_upd_data = ud;
        issue_valid = iv; issue_size = sz; issue_ctrl = ct; issue_pred = pr; issue_pred_inv = pi;
        e = model(m_mask, m_width, iv, sz, ct, pr, pi);
        if (dv) begin
            m_width = code_width(dw);
            m_mask  = ones_below(m_width);
        end else if (uv) begin
            m_mask = ud & ones_below(m_width);
        end
        @(posedge clk);
        @(negedge clk);
        if (tag != "") t = tag;
        else if (e[34]) t = "R1";
        else if (e[33]) t = "R6";
        else if (e[32]) t = "R7";
        else if (!iv) t = "R11";
        else if (ct[3]) t = "R4";
        else t = "R3";
        check(t, "lane_en", lane_en_q, e[31:0]);
        check("R11", "valid", {31'b0, out_valid_q}, {31'b0, e[35]});
        check("R1", "err_size", {31'b0, err_size_q}, {31'b0, e[34]});
        check("R6", "err_align", {31'b0, err_align_q}, {31'b0, e[33]});
        check("R7", "err_range", {31'b0, err_range_q}, {31'b0, e[32]});
        check(dv ? "R9" : "R10", "exec_mask", exec_mask_q, m_mask);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", "reset lane_en", lane_en_q, '0);
        check("R12", "reset mask", exec_mask_q, '0);
        check("R12", "reset flags", {28'b0, out_valid_q, err_size_q, err_align_q, err_range_q}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset width is 8, so a 16-lane group is out of range
        cycle(0, 0, 0, 0, 1, 3'd4, 4'b1000, '1, 0, "R12");
        // R9: full-width dispatch
        cycle(1, 2'd2, 1, 32'h1234_5678, 0, 0, 0, 0, 0, "R9");
        cycle(0, 0, 0, 0, 1, 3'd5, 4'b0000, '1, 0, "R3");
        // R2: group 3 starts at lane 12
        cycle(0, 0, 0, 0, 1, 3'd2, 4'b1011, '1, 0, "R2");
        // R5: inverted predicate selects low nibble of the 8-lane group
        cycle(0, 0, 0, 0, 1, 3'd3, 4'b0000, 32'h0000_00F0, 1, "R5");
        // R6: 8 lanes starting at lane 4
        cycle(0, 0, 0, 0, 1, 3'd3, 4'b0001, '1, 0, "R6");
        // R1: illegal size codes
        cycle(0, 0, 0, 0, 1, 3'd6, 4'b0000, '1, 0, "R1");
        cycle(0, 0, 0, 0, 1, 3'd7, 4'b1010, '1, 0, "R1");
        // R7: width 8; group at lane 8 is out, group ending at lane 7 is in
        cycle(1, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R9");
        cycle(0, 0, 0, 0, 1, 3'd3, 4'b0010, '1, 0, "R7");
        cycle(0, 0, 0, 0, 1, 3'd3, 4'b0000, '1, 0, "R7");
        // R10: update and issue together; issue sees the old mask
        cycle(1, 2'd2, 0, 0, 0, 0, 0, 0, 0, "R9");
        cycle(0, 0, 1, 32'h0000_000F, 1, 3'd3, 4'b0000, '1, 0, "R10");
        cycle(0, 0, 0, 0, 1, 3'd3, 4'b0000, '1, 0, "R10");
        // R4: no-mask ignores a cleared mask
        cycle(0, 0, 1, 32'h0, 0, 0, 0, 0, 0, "R10");
        cycle(0, 0, 0, 0, 1, 3'd4, 4'b1100, 32'hFF0F_FFFF, 0, "R4");
        // R9: dispatch beats update in the same cycle
        cycle(1, 2'd1, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R9");
        // random mix
        void'($urandom(32'd2024));
        for (int n = 0; n < 800; n++) begin
            cycle(($urandom % 16) == 0, 2'($urandom % 4), ($urandom % 4) == 0, $urandom,
                  ($urandom % 4) != 0, 3'($urandom % 8), 4'($urandom % 16),
                  $urandom, 1'($urandom % 2), "");
        end
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule